// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits beside a UART transmitter and drives the direction pin of a half-duplex RS-485 transceiver. It watches the transmit FIFO write strobe, the FIFO-empty flag, the busy flag of the serial shifter, and a tick from the baud generator that fires sixteen times per bit. From these it decides when the line belongs to the local transmitter. It also produces the transmit-empty interrupt request.

The direction output is held in the transmit state from the first byte write until the last frame has fully left the shifter. It then stays there for one more bit time, so the final stop bit is not cut short by the transceiver turning around. A polarity input selects the active level. A mode input chooses between two interrupt timings. In the legacy timing the interrupt fires when the holding FIFO empties. In the delayed timing, used with automatic direction, it fires only once the shifter has also gone idle.

The controller is a three-state machine with these states:
- `DIR_RX_IDLE`: the line is released.
- `DIR_TX_BUSY`: data is queued or shifting.
- `DIR_TX_TURN`: the turnaround bit time is running.

Its transitions are:
- ENTER_TX: `DIR_RX_IDLE` to `DIR_TX_BUSY` on any write or pending data.
- START_TURN: `DIR_TX_BUSY` to `DIR_TX_TURN` when the FIFO and shifter are both idle.
- RESTART: `DIR_TX_TURN` to `DIR_TX_BUSY` on new activity.
- RELEASE: `DIR_TX_BUSY` or `DIR_TX_TURN` to `DIR_RX_IDLE` on the sixteenth idle tick.
- DISABLE: any state to `DIR_RX_IDLE` when automatic direction is off.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset, with `dir_invert` = 0, `dir_out` is 1 (the receive level) and `tx_irq` is 0.
- R2: While `auto_en` is 0, `dir_out` sits at the receive level from the next cycle on, and any partly counted turnaround is discarded.
- R3: With `auto_en` = 1, a cycle with `fifo_wr` = 1 puts `dir_out` at the transmit level (0 when `dir_invert` = 0) in the following cycle.
- R4: With `auto_en` = 1, `dir_out` stays at the transmit level for every cycle that follows a cycle in which `fifo_empty` = 0 or `shift_busy` = 1.
- R5: Ticks are counted only in cycles where `fifo_wr` = 0, `fifo_empty` = 1 and `shift_busy` = 0. The count starts with the first such cycle. On the sixteenth counted `bit_tick`, `dir_out` returns to the receive level in the following cycle, and it never returns there without a tick.
- R6: Activity during the turnaround (a write, a non-empty FIFO or a busy shifter) keeps `dir_out` at the transmit level and restarts the count from zero.
- R7: `dir_invert` = 1 swaps the two levels: receive is 0 and transmit is 1. The change takes effect in the same cycle.
- R8: With `auto_en` = 0, `tx_irq` rises in the cycle after `fifo_empty` goes from 0 to 1, even while `shift_busy` = 1.
- R9: With `auto_en` = 1, `tx_irq` rises in the cycle after the condition (`fifo_empty` = 1 and `shift_busy` = 0) becomes true, and never while the shifter is busy.
- R10: `tx_irq` is a level signal. A cycle with `fifo_wr` = 1 clears it with top priority. A cycle with `status_rd` = 1 clears it unless a new empty event arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_en | input | 1 | Automatic direction enable; also selects delayed interrupt timing |
| dir_invert | input | 1 | Inverts the direction output levels |
| fifo_wr | input | 1 | One-cycle strobe for a byte written into the TX FIFO |
| fifo_empty | input | 1 | TX FIFO holds no characters |
| shift_busy | input | 1 | Transmit shifter is sending a frame |
| bit_tick | input | 1 | 16x oversampling tick from the baud generator |
| status_rd | input | 1 | Status read strobe that clears the interrupt |
| dir_out | output | 1 | Transceiver direction pin |
| tx_irq | output | 1 | Transmit-empty interrupt request (level) |

## Verification
The assertions watch, on every cycle:
- the receive level while the block is disabled;
- the transmit level after a write or while data is pending;
- that a release only ever follows a tick;
- that a write clears the interrupt;
- that the interrupt only rises after an empty FIFO and, in the delayed timing, after an idle shifter.

The exact release tick, the restart of the count when a byte arrives mid-turnaround, and the cycle of the interrupt under each timing depend on the history of ticks and frames. Only the bench scenarios can show these, by comparing against a model of a FIFO and shifter with variable frame lengths.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        DIR_RX_IDLE = 2'd0,
        DIR_TX_BUSY = 2'd1,
        DIR_TX_TURN = 2'd2
    } dir_state_e;

endpackage

// File: rtl/rs485_turn_timer.sv
module rs485_turn_timer #(
    parameter int BIT_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign done = en && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && tick) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rs485_txe_irq.sv
module rs485_txe_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic delayed,
    input  logic fifo_empty,
    input  logic shift_busy,
    input  logic fifo_wr,
    input  logic status_rd,
    output logic irq
);
    logic cond;
    logic cond_q;

    always_comb begin
        if (delayed) begin
            cond = fifo_empty && !shift_busy;
        end else begin
            cond = fifo_empty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b1;
            irq    <= 1'b0;
        end else begin
            cond_q <= cond;
            if (fifo_wr) begin
                irq <= 1'b0;
            end else if (cond && !cond_q) begin
                irq <= 1'b1;
            end else if (status_rd) begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int BIT_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic dir_invert,
    input  logic fifo_wr,
    input  logic fifo_empty,
    input  logic shift_busy,
    input  logic bit_tick,
    input  logic status_rd,
    output logic dir_out,
    output logic tx_irq
);
    dir_state_e state;
    dir_state_e state_nx;
    logic       activity;
    logic       turn_done;
    logic       timer_en;
    logic       timer_clr;

    assign activity  = fifo_wr || !fifo_empty || shift_busy;
    assign timer_en  = auto_en && (state != DIR_RX_IDLE) && !activity;
    assign timer_clr = !auto_en || activity || (state == DIR_RX_IDLE);

    rs485_turn_timer #(
        .BIT_TICKS(BIT_TICKS)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (timer_clr),
        .en   (timer_en),
        .tick (bit_tick),
        .done (turn_done)
    );

    rs485_txe_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .delayed   (auto_en),
        .fifo_empty(fifo_empty),
        .shift_busy(shift_busy),
        .fifo_wr   (fifo_wr),
        .status_rd (status_rd),
        .irq       (tx_irq)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            DIR_RX_IDLE: begin
                if (auto_en && activity) state_nx = DIR_TX_BUSY;      // ENTER_TX
            end
            DIR_TX_BUSY: begin
                if (!auto_en)       state_nx = DIR_RX_IDLE;           // DISABLE
                else if (activity)  state_nx = DIR_TX_BUSY;
                else if (turn_done) state_nx = DIR_RX_IDLE;           // RELEASE
                else                state_nx = DIR_TX_TURN;           // START_TURN
            end
            DIR_TX_TURN: begin
                if (!auto_en)       state_nx = DIR_RX_IDLE;           // DISABLE
                else if (activity)  state_nx = DIR_TX_BUSY;           // RESTART
                else if (turn_done) state_nx = DIR_RX_IDLE;           // RELEASE
            end
            default: state_nx = DIR_RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DIR_RX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        if (state == DIR_RX_IDLE) begin
            dir_out = !dir_invert;
        end else begin
            dir_out = dir_invert;
        end
    end
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk
    import rs485_dir_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       auto_en,
    input logic       dir_invert,
    input logic       fifo_wr,
    input logic       fifo_empty,
    input logic       shift_busy,
    input logic       bit_tick,
    input logic       dir_out,
    input logic       tx_irq,
    input dir_state_e st
);
    // R2
    disabled_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (dir_out == !dir_invert));

    // R3
    write_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fifo_wr) |=> (dir_out == dir_invert));

    // R4
    hold_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && (!fifo_empty || shift_busy)) |=> (dir_out == dir_invert));

    // R5
    release_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st == DIR_RX_IDLE) && $past(auto_en)) |-> $past(bit_tick));

    // R10
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !tx_irq);

    // R8
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> $past(fifo_empty));

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_irq) && $past(auto_en)) |-> !$past(shift_busy));
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_en),
    .dir_invert(dir_invert),
    .fifo_wr   (fifo_wr),
    .fifo_empty(fifo_empty),
    .shift_busy(shift_busy),
    .bit_tick  (bit_tick),
    .dir_out   (dir_out),
    .tx_irq    (tx_irq),
    .st        (state)
);

// File: tb/rs485_dir_ctrl_test.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_test;
    localparam int DEPTH = 32;
    localparam int TICKS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_en = 1'b0;
    logic dir_invert = 1'b0;
    logic fifo_wr = 1'b0;
    logic fifo_empty = 1'b1;
    logic shift_busy = 1'b0;
    logic bit_tick = 1'b0;
    logic status_rd = 1'b0;
    logic dir_out;
    logic tx_irq;

    int checks = 0;
    int fails = 0;
    int fifo_cnt = 0;
    int sh_left = 0;
    int frame_bits = 10;
    bit m_tx = 0;
    int m_cnt = 0;
    bit m_irq = 0;
    bit m_cond_q = 1;

    always #2.5 clk = ~clk;

    rs485_dir_ctrl #(.BIT_TICKS(TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .dir_invert(dir_invert),
        .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .shift_busy(shift_busy),
        .bit_tick(bit_tick), .status_rd(status_rd), .dir_out(dir_out), .tx_irq(tx_irq)
    );

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_dir();
        return m_tx ? dir_invert : !dir_invert;
    endfunction

    task automatic model(bit wr, bit rd, bit tk);
        bit empty = (fifo_cnt == 0);
        bit busy = (sh_left > 0);
        bit act = wr || !empty || busy;
        bit cond = auto_en ? (empty && !busy) : empty;
        if (wr) m_irq = 0;
        else if (cond && !m_cond_q) m_irq = 1;
        else if (rd) m_irq = 0;
        m_cond_q = cond;
        if (!auto_en) begin
            m_tx = 0; m_cnt = 0;
        end else if (act) begin
            m_tx = 1; m_cnt = 0;
        end else if (m_tx && tk) begin
            m_cnt++;
            if (m_cnt == TICKS) begin m_tx = 0; m_cnt = 0; end
        end
    endtask

    // one cycle; called just after a falling edge, checks at the next one
    task automatic step(bit wr, bit rd, bit tk);
        bit rd_or_wr = wr || rd;
        fifo_wr = wr;
        status_rd = rd;
        bit_tick = tk;
        fifo_empty = (fifo_cnt == 0);
        shift_busy = (sh_left > 0);
        model(wr, rd, tk);
        if (sh_left > 0) begin
            if (tk) sh_left--;
        end else if (fifo_cnt > 0) begin
            fifo_cnt--;
            sh_left = frame_bits * TICKS;
        end
        if (wr && fifo_cnt < DEPTH) fifo_cnt++;
        @(negedge clk);
        if (!auto_en) check("R2 dir", dir_out, exp_dir());
        else if (dir_invert) check("R7 dir", dir_out, exp_dir());
        else check("R5 dir", dir_out, exp_dir());
        if (rd_or_wr) check("R10 irq", tx_irq, m_irq);
        else if (auto_en) check("R9 irq", tx_irq, m_irq);
        else check("R8 irq", tx_irq, m_irq);
    endtask

    // ticks every cycle; returns idle cycles counted until the line is released
    task automatic run_release(output int n_rel, output int n_irq, input int restart_at);
        n_rel = 0;
        n_irq = 0;
        for (int i = 0; i < 5000; i++) begin
            bit idle = (fifo_cnt == 0) && (sh_left == 0);
            if (idle && n_rel == restart_at) begin
                step(1, 0, 1);
                check("R6 hold", dir_out, dir_invert);
                n_rel = 0;
                restart_at = -1;
                continue;
            end
            step(0, 0, 1);
            if (idle) n_rel++;
            if (tx_irq && n_irq == 0) n_irq = n_rel;
            if (dir_out == !dir_invert) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n_rel;
        int n_irq;
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        check("R1 dir", dir_out, 1'b1);
        check("R1 irq", tx_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dir after release", dir_out, 1'b1);

        // legacy timing: irq while the shifter still sends
        frame_bits = 2;
        step(1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        check("R8 irq while busy", tx_irq, 1'b1);
        check("R8 shifter busy", shift_busy, 1'b1);
        step(0, 1, 0);
        check("R10 status read clears", tx_irq, 1'b0);
        for (int i = 0; i < 80; i++) step(0, 0, 1);

        // automatic direction, exact release tick and delayed irq
        auto_en = 1'b1;
        step(1, 0, 1);
        check("R3 write enters tx", dir_out, 1'b0);
        run_release(n_rel, n_irq, -1);
        check("R5 release on 16th idle tick", n_rel == TICKS, 1'b1);
        check("R9 irq on first idle cycle", n_irq == 1, 1'b1);

        // restart mid turnaround
        step(1, 0, 1);
        run_release(n_rel, n_irq, 10);
        check("R6 full count after restart", n_rel == TICKS, 1'b1);

        // inverted polarity
        dir_invert = 1'b1;
        @(negedge clk);
        check("R7 inverted receive", dir_out, 1'b0);
        step(1, 0, 1);
        check("R7 inverted transmit", dir_out, 1'b1);
        run_release(n_rel, n_irq, -1);
        check("R7 inverted release count", n_rel == TICKS, 1'b1);
        step(1, 0, 0);
        check("R10 write clears irq", tx_irq, 1'b0);

        // disable mid transfer
        auto_en = 1'b0;
        step(0, 0, 1);
        check("R2 disable releases", dir_out, !dir_invert);

        // random phase
        for (int blk = 0; blk < 6; blk++) begin
            auto_en = $urandom % 2;
            dir_invert = $urandom % 2;
            frame_bits = 9 + ($urandom % 4);
            for (int i = 0; i < 2000; i++) begin
                bit wr = (fifo_cnt < DEPTH) && ($urandom % 30 == 0);
                bit rd = ($urandom % 50 == 0);
                bit tk = ($urandom % 2 == 0);
                if ($urandom % 600 == 0) auto_en = !auto_en;
                step(wr, rd, tk);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule